// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Selectable Parity

This block receives asynchronous serial frames on a single input line. The line first passes through a two-flop synchroniser. The block then samples it sixteen times per bit period, paced by a tick pulse that arrives on the base clock. When a frame finishes, the assembled byte is moved into a holding buffer and a completion interrupt pulses. Parity, framing and overrun conditions are gathered into sticky flags. Any frame that carries an error raises a one-cycle error interrupt.

A two-bit mode register chooses one of four parity handling options. In the first, no parity slot is present. In the second, a slot is received but never judged. The other two check for odd or for even parity. The mode register can be written only while both the transmit enable and the receive enable are low. Reception runs only while the master enable and the receive enable are both high. Dropping reception leaves the buffer untouched. Holding it low for two base-clock cycles clears the receive state and the error flags.

Top module: `serial_rx_unit`

## Requirements
- R1: A frame is one low start bit, then 8 data bits with the least significant bit first, then a parity slot only when the mode is not 00, then one stop bit. Each bit lasts 16 sample ticks. After reset the mode register holds 00.
- R2: With mode 01 (zero parity), the parity slot is received but not judged. `parity_err` never sets and the parity bit raises no error interrupt, whatever its value.
- R3: With mode 10 (odd), a parity error is flagged when the number of ones across the data bits and the parity bit is even. With mode 11 (even), it is flagged when that number is odd.
- R4: While `rx_enable` is low, no start bit is detected, no frame completes, and `rx_buffer` keeps its value.
- R5: Reception is active only while `uart_enable` and `rx_enable` are both high. With `uart_enable` low, frames are ignored even if `rx_enable` is high.
- R6: At the end of every received frame, `rx_buffer` takes the new byte and `rx_done_irq` pulses high for exactly one cycle. Both change in the same cycle.
- R7: A low level on the line counts as a start bit only if it is still low at the bit's mid-point, eight ticks later. Otherwise the receiver returns to idle and produces no frame.
- R8: A write through `mode_wr` changes `parity_mode` only when both `tx_enable` and `rx_enable` are low. In any other case the write is ignored.
- R9: Holding the receive path inactive for 2 or more consecutive cycles clears the receive state and the `parity_err`, `framing_err` and `overrun_err` flags. `rx_buffer` is not changed.
- R10: A stop bit sampled low sets `framing_err`.
- R11: If a frame completes while the previous byte has not been taken with `buf_read`, `overrun_err` sets and the buffer is overwritten with the new byte.
- R12: `rx_err_irq` pulses high for one cycle, in the same cycle as `rx_done_irq`, for every frame that has a parity, framing or overrun error.
- R13: After reset, `rx_buffer` reads 0, all error flags are 0, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_serial | input | 1 | Serial input line, idle high |
| uart_enable | input | 1 | Master enable |
| rx_enable | input | 1 | Receive enable |
| tx_enable | input | 1 | Transmit enable, used only for the mode lock |
| mode_wr | input | 1 | Write strobe for the parity mode |
| mode_wdata | input | 2 | New parity mode value |
| buf_read | input | 1 | Marks the buffered byte as taken |
| parity_mode | output | 2 | Current parity mode |
| rx_buffer | output | 8 | Last received byte |
| rx_done_irq | output | 1 | Frame completion pulse |
| rx_err_irq | output | 1 | Error pulse for a faulty frame |
| parity_err | output | 1 | Sticky parity error flag |
| framing_err | output | 1 | Sticky framing error flag |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
The hardest condition to reach from the ports is a frame whose parity or stop bit is wrong. The bench drives the serial line bit by bit, so it builds each frame itself. It computes the correct parity bit for the selected mode and then inverts it or forces the stop bit low on purpose. Each table entry first drops reception for several cycles, which clears the sticky flags, so every error it sees comes from that one frame. Overrun is reached by sending two frames in a row without `buf_read`. A false start is reached by pulling the line low for fewer than eight ticks.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], d_i};
    end

    // The line idles high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              act_i,
    input  logic              line_i,
    input  par_mode_e         mode_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shift;
        logic              perr;
        logic              ferr;
        logic              done;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        if (!act_i) begin
            fr_d.state = ST_IDLE;
            fr_d.cnt   = '0;
            fr_d.idx   = '0;
        end else if (tick_i) begin
            unique case (fr_q.state)
                ST_IDLE: begin
                    if (!line_i) begin
                        fr_d.state = ST_START;
                        fr_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (fr_q.cnt == MID) begin
                        fr_d.cnt = '0;
                        if (!line_i) begin
                            fr_d.state = ST_DATA;
                            fr_d.idx   = '0;
                            fr_d.perr  = 1'b0;
                            fr_d.ferr  = 1'b0;
                        end else begin
                            fr_d.state = ST_IDLE;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (fr_q.cnt == LAST) begin
                        fr_d.cnt   = '0;
                        fr_d.shift = {line_i, fr_q.shift[DATA_W-1:1]};
                        if (fr_q.idx == TOP) begin
                            fr_d.state = (mode_i == PAR_NONE) ? ST_STOP : ST_PAR;
                        end else begin
                            fr_d.idx = fr_q.idx + IDX_W'(1);
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_PAR: begin
                    if (fr_q.cnt == LAST) begin
                        fr_d.cnt   = '0;
                        fr_d.state = ST_STOP;
                        unique case (mode_i)
                            PAR_ODD:  fr_d.perr = ~(^{fr_q.shift, line_i});
                            PAR_EVEN: fr_d.perr =   ^{fr_q.shift, line_i};
                            default:  fr_d.perr = 1'b0;
                        endcase
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (fr_q.cnt == LAST) begin
                        fr_d.cnt   = '0;
                        fr_d.ferr  = ~line_i;
                        fr_d.done  = 1'b1;
                        fr_d.state = ST_IDLE;
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                default: fr_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{state: ST_IDLE, default: '0};
        else        fr_q <= fr_d;
    end

    assign done_o = fr_q.done;
    assign data_o = fr_q.shift;
    assign perr_o = fr_q.perr;
    assign ferr_o = fr_q.ferr;

    // R2: a frame finished in zero-parity mode never reports parity trouble
    assert_zero_mode_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_i == PAR_ZERO) |-> !perr_o);

    // R4: a frame can only finish if reception was active one cycle before
    assert_done_needs_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(act_i));

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
    parameter int DATA_W     = 8,
    parameter int CLR_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              rd_ack_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_irq_o,
    output logic              err_irq_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              ovr_o
);

    localparam int OFF_W = $clog2(CLR_CYCLES + 1);
    localparam logic [OFF_W-1:0] OFF_MAX  = OFF_W'(CLR_CYCLES);
    localparam logic [OFF_W-1:0] OFF_CLR  = OFF_W'(CLR_CYCLES - 1);

    typedef struct packed {
        logic [DATA_W-1:0] buffer;
        logic              full;
        logic              perr;
        logic              ferr;
        logic              ovr;
        logic              done_irq;
        logic              err_irq;
        logic [OFF_W-1:0]  off_cnt;
    } hold_t;

    hold_t hd_d, hd_q;
    logic  ovr_new;

    always_comb begin
        hd_d          = hd_q;
        hd_d.done_irq = 1'b0;
        hd_d.err_irq  = 1'b0;
        ovr_new       = 1'b0;

        if (act_i) begin
            hd_d.off_cnt = '0;
        end else begin
            if (hd_q.off_cnt != OFF_MAX) hd_d.off_cnt = hd_q.off_cnt + OFF_W'(1);
            if (hd_q.off_cnt >= OFF_CLR) begin
                hd_d.perr = 1'b0;
                hd_d.ferr = 1'b0;
                hd_d.ovr  = 1'b0;
            end
        end

        if (rd_ack_i) hd_d.full = 1'b0;

        if (done_i) begin
            ovr_new       = hd_q.full && !rd_ack_i;
            hd_d.buffer   = data_i;
            hd_d.full     = 1'b1;
            hd_d.done_irq = 1'b1;
            hd_d.perr     = hd_d.perr | perr_i;
            hd_d.ferr     = hd_d.ferr | ferr_i;
            hd_d.ovr      = hd_d.ovr | ovr_new;
            hd_d.err_irq  = perr_i | ferr_i | ovr_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign data_o     = hd_q.buffer;
    assign done_irq_o = hd_q.done_irq;
    assign err_irq_o  = hd_q.err_irq;
    assign perr_o     = hd_q.perr;
    assign ferr_o     = hd_q.ferr;
    assign ovr_o      = hd_q.ovr;

    // R4: without a finished frame the buffer keeps its contents
    assert_buffer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(data_o));

    // R6: the completion pulse shows the byte that the frame logic delivered
    assert_irq_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |-> (data_o == $past(data_i)));

    // R12: an error pulse always comes with a completion pulse and a raised flag
    assert_err_irq_flagged_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> (done_irq_o && (perr_o || ferr_o || ovr_o)));

    // R9: two inactive cycles leave every error flag clear
    assert_reinit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_i && $past(!act_i)) |=> !(perr_o || ferr_o || ovr_o));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CLR_CYCLES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rx_serial,
    input  logic              uart_enable,
    input  logic              rx_enable,
    input  logic              tx_enable,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    input  logic              buf_read,
    output logic [1:0]        parity_mode,
    output logic [DATA_W-1:0] rx_buffer,
    output logic              rx_done_irq,
    output logic              rx_err_irq,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun_err
);

    typedef struct packed {
        par_mode_e mode;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic              rx_active;
    logic              line_sync;
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_perr;
    logic              fr_ferr;

    always_comb begin
        rx_active = uart_enable & rx_enable;
        cfg_d     = cfg_q;
        if (mode_wr && !tx_enable && !rx_enable) cfg_d.mode = par_mode_e'(mode_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mode: PAR_NONE};
        else        cfg_q <= cfg_d;
    end

    assign parity_mode = cfg_q.mode;

    serial_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_serial),
        .q_o   (line_sync)
    );

    serial_rx_frame #(
        .DATA_W (DATA_W),
        .OVS    (OVS)
    ) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sample_tick),
        .act_i  (rx_active),
        .line_i (line_sync),
        .mode_i (cfg_q.mode),
        .done_o (fr_done),
        .data_o (fr_data),
        .perr_o (fr_perr),
        .ferr_o (fr_ferr)
    );

    serial_rx_hold #(
        .DATA_W     (DATA_W),
        .CLR_CYCLES (CLR_CYCLES)
    ) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (rx_active),
        .rd_ack_i   (buf_read),
        .done_i     (fr_done),
        .data_i     (fr_data),
        .perr_i     (fr_perr),
        .ferr_i     (fr_ferr),
        .data_o     (rx_buffer),
        .done_irq_o (rx_done_irq),
        .err_irq_o  (rx_err_irq),
        .perr_o     (parity_err),
        .ferr_o     (framing_err),
        .ovr_o      (overrun_err)
    );

    // R8: the mode holds while either enable is high
    assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable || rx_enable) |=> $stable(parity_mode));

endmodule

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;

    localparam int BIT_CLKS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_serial = 1'b1;
    logic       uart_enable = 1'b0;
    logic       rx_enable = 1'b0;
    logic       tx_enable = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       buf_read = 1'b0;
    logic [1:0] parity_mode;
    logic [7:0] rx_buffer;
    logic       rx_done_irq, rx_err_irq, parity_err, framing_err, overrun_err;

    int   n_run = 0;
    int   n_fail = 0;
    int   done_cnt = 0;
    int   err_cnt = 0;
    logic [7:0] cap_buf = 8'h00;
    bit   finished = 1'b0;

    serial_rx_unit i_serial_rx_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .rx_serial   (rx_serial),
        .uart_enable (uart_enable),
        .rx_enable   (rx_enable),
        .tx_enable   (tx_enable),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .buf_read    (buf_read),
        .parity_mode (parity_mode),
        .rx_buffer   (rx_buffer),
        .rx_done_irq (rx_done_irq),
        .rx_err_irq  (rx_err_irq),
        .parity_err  (parity_err),
        .framing_err (framing_err),
        .overrun_err (overrun_err)
    );

    always #4 clk = ~clk;

    // Tick every second clock: 16 ticks make 32 clocks per bit
    always @(posedge clk) sample_tick <= ~sample_tick;

    always @(negedge clk) begin
        if (rx_done_irq) begin
            done_cnt++;
            cap_buf = rx_buffer;
        end
        if (rx_err_irq) err_cnt++;
    end

    // Vector fields: {mode[1:0], data[7:0], flip_parity, stop_bit}
    localparam logic [11:0] VEC [0:8] = '{
        {2'b00, 8'hA5, 1'b0, 1'b1},
        {2'b01, 8'h3C, 1'b0, 1'b1},
        {2'b01, 8'h3C, 1'b1, 1'b1},
        {2'b10, 8'h81, 1'b0, 1'b1},
        {2'b10, 8'h81, 1'b1, 1'b1},
        {2'b11, 8'h7E, 1'b0, 1'b1},
        {2'b11, 8'h01, 1'b1, 1'b1},
        {2'b00, 8'hFF, 1'b0, 1'b0},
        {2'b11, 8'h00, 1'b0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h, expected %0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rx_serial = b;
        clocks(BIT_CLKS);
    endtask

    task automatic send_frame(input logic [1:0] mode, input logic [7:0] data,
                              input logic flip, input logic stop);
        logic par;
        case (mode)
            2'b10:   par = ~(^data);
            2'b11:   par = ^data;
            default: par = 1'b0;
        endcase
        par = par ^ flip;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(data[i]);
        if (mode != 2'b00) send_bit(par);
        send_bit(stop);
        rx_serial = 1'b1;
        clocks(BIT_CLKS);
    endtask

    task automatic write_mode(input logic [1:0] m);
        mode_wdata = m;
        mode_wr    = 1'b1;
        clocks(1);
        mode_wr    = 1'b0;
        clocks(1);
    endtask

    task automatic read_buf();
        buf_read = 1'b1;
        clocks(1);
        buf_read = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        report();
    end

    initial begin
        int d0, e0;
        logic [7:0] held;
        clocks(3);
        rst_n = 1'b1;
        clocks(2);

        // R13 reset state, R1 default mode 00
        check("R13 buffer", rx_buffer, 0);
        check("R13 flags", {parity_err, framing_err, overrun_err}, 0);
        check("R13 irqs", {rx_done_irq, rx_err_irq}, 0);
        check("R1 reset mode", parity_mode, 0);

        uart_enable = 1'b1;

        // Table walk: R1 R2 R3 R6 R10 R12
        for (int v = 0; v < 9; v++) begin
            logic [1:0] m;
            logic [7:0] dat;
            logic       fl, st, pexp;
            {m, dat, fl, st} = VEC[v];
            pexp = fl && m[1];
            rx_enable = 1'b0;
            clocks(3);
            write_mode(m);
            read_buf();
            rx_enable = 1'b1;
            clocks(2);
            d0 = done_cnt;
            e0 = err_cnt;
            send_frame(m, dat, fl, st);
            check("R6 one done pulse", done_cnt - d0, 1);
            check("R1 byte at done", cap_buf, dat);
            check("R1 buffer", rx_buffer, dat);
            if (m == 2'b01) check("R2 zero mode no perr", parity_err, 0);
            else            check("R3 parity flag", parity_err, pexp);
            check("R10 framing flag", framing_err, !st);
            check("R12 err pulse", err_cnt - e0, (pexp || !st) ? 1 : 0);
        end

        // R8 mode writes locked while an enable is high
        rx_enable = 1'b0;
        clocks(3);
        write_mode(2'b10);
        check("R8 write accepted", parity_mode, 2'b10);
        rx_enable = 1'b1;
        write_mode(2'b01);
        check("R8 ignored rx_enable", parity_mode, 2'b10);
        rx_enable = 1'b0;
        tx_enable = 1'b1;
        write_mode(2'b11);
        check("R8 ignored tx_enable", parity_mode, 2'b10);
        tx_enable = 1'b0;
        write_mode(2'b00);
        check("R8 write accepted again", parity_mode, 2'b00);
        read_buf();

        // R4 disabled reception ignores frames and keeps the buffer
        held = rx_buffer;
        d0 = done_cnt;
        send_frame(2'b00, 8'h5A, 1'b0, 1'b1);
        check("R4 no done while off", done_cnt - d0, 0);
        check("R4 buffer kept", rx_buffer, held);

        // R5 master enable low blocks reception
        uart_enable = 1'b0;
        rx_enable = 1'b1;
        d0 = done_cnt;
        send_frame(2'b00, 8'h5A, 1'b0, 1'b1);
        check("R5 no done without master", done_cnt - d0, 0);
        check("R5 buffer kept", rx_buffer, held);
        uart_enable = 1'b1;
        clocks(2);

        // R7 short low pulse is a glitch
        d0 = done_cnt;
        rx_serial = 1'b0;
        clocks(8);
        rx_serial = 1'b1;
        clocks(BIT_CLKS * 12);
        check("R7 glitch ignored", done_cnt - d0, 0);
        send_frame(2'b00, 8'hC3, 1'b0, 1'b1);
        check("R7 next frame count", done_cnt - d0, 1);
        check("R7 next frame byte", rx_buffer, 8'hC3);

        // R11 overrun: second frame without a read
        e0 = err_cnt;
        send_frame(2'b00, 8'h96, 1'b0, 1'b1);
        check("R11 overrun flag", overrun_err, 1);
        check("R11 buffer overwritten", rx_buffer, 8'h96);
        check("R12 overrun err pulse", err_cnt - e0, 1);

        // R9 two inactive cycles clear flags, buffer stays
        rx_enable = 1'b0;
        clocks(2);
        rx_enable = 1'b1;
        clocks(2);
        check("R9 flags cleared", {parity_err, framing_err, overrun_err}, 0);
        check("R9 buffer retained", rx_buffer, 8'h96);
        read_buf();
        send_frame(2'b00, 8'h24, 1'b0, 1'b1);
        check("R9 receives after reinit", rx_buffer, 8'h24);
        check("R9 no overrun after read", overrun_err, 0);

        report();
    end

endmodule